// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is a synthesizable model of the host-facing front end of an 8-bit NAND flash device with a shared command, address and data bus. It watches the chip-enable, command-latch, address-latch, write-strobe and read-strobe inputs. It samples them on a system clock and finds the strobe edges. From those edges it decodes each bus cycle as a command, address or data byte. Operations are entered as a setup byte followed by a confirm byte. The setup byte also decides how many address bytes are expected and what they mean.

A page register sits between the bus and a small on-chip cell array. A read copies one page from the array into the register, and the host then streams it out with the read strobe. A program sends the register into the array one byte per clock. An erase sets every stored page of the selected block to all ones. While any of these runs, the ready/busy output is held low. A status byte and a reset command stay usable during that time. The current operation and the latched column and row are brought out so that a testbench can follow the decoder.

Top module: `nand_front`

## Requirements
- R1: A bus byte is taken on a rising edge of `we_n` only while `ce_n` is low. `cle` high marks it as a command and `ale` high marks it as an address. With `ce_n` high, no strobe changes any state.
- R2: After the read setup (00h) or the program setup (80h), four address bytes are taken in this order: column bits 7:0, column bits 11:8 (the upper nibble of that byte is discarded), row bits 7:0, row bits 15:8. Address bytes after the fourth are ignored.
- R3: After the erase setup (60h), only two address bytes are taken: row bits 7:0, then row bits 15:8. Further address bytes leave the row unchanged.
- R4: 30h after the read address starts a page load with `rb_n` low (`busy_op` = 1). When the load ends, each falling edge of `re_n` returns the byte at the current column and then advances the column by one.
- R5: 10h after the program setup starts programming (`busy_op` = 2). Each cell becomes the AND of its old value with the byte loaded at that column. Columns not loaded since 80h leave the cell unchanged, and no other row is affected.
- R6: D0h after the erase address sets every stored page of the addressed block to FFh (`busy_op` = 3). Pages in other blocks are left unchanged. A block holds `PAGES_PER_BLOCK` pages.
- R7: During data output, 05h, two column bytes and then E0h move the output column to any place in the page without a new page load.
- R8: During program data entry, 85h and then two column bytes move the input column, and data entry continues from there.
- R9: 70h makes each later `re_n` fall return a status byte: bit 7 is `wp_n`, bit 6 is ready, bit 0 is the fail flag, and the other bits are 0. It is accepted while busy and stays in force until the next command taken while ready.
- R10: FFh is accepted at any time. It aborts the running operation, clears the decoder, the fail flag and the error flag, and holds `rb_n` low for exactly `RST_CYCLES` clocks (`busy_op` = 4), even when it is issued while ready.
- R11: While busy, every command other than FFh and 70h is ignored, and so are address and data bytes. The column, the row and the running operation do not change.
- R12: A command byte outside the set 00h, 30h, 80h, 85h, 10h, 60h, D0h, 05h, E0h, 70h, FFh, or a confirm or move byte given in the wrong state, returns the decoder to idle and sets `cmd_err`. The next accepted command clears it.
- R13: With `wp_n` low, the program and erase confirms are refused. No busy period starts, the array is unchanged and the status fail bit is set.
- R14: A page holds `MAIN_BYTES` + `SPARE_BYTES` columns (2112 by default, with columns 2048 to 2111 as the spare area). Writes at or beyond column 2112 are dropped, and reads there return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks the bus byte as a command |
| ale | input | 1 | Marks the bus byte as an address |
| we_n | input | 1 | Write strobe; the byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; output advances on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| dq_in | input | 8 | Bus byte from the host |
| dq_out | output | 8 | Bus byte to the host |
| dq_oe | output | 1 | Output enable for `dq_out` (chip enabled and read strobe low) |
| rb_n | output | 1 | Ready/busy; low while busy and pulled high otherwise |
| cmd_err | output | 1 | Set by an undefined or misplaced command |
| busy_op | output | 3 | Running operation: 0 none, 1 read, 2 program, 3 erase, 4 reset |
| col_addr | output | 12 | Current column pointer |
| row_addr | output | 16 | Latched row |

## Verification
The assertions assume that the bus inputs are synchronous to `clk` and stay steady for at least one clock around each strobe edge, so that every edge is seen once. They also assume that a strobe never rises or falls while `cle` or `ale` is changing. The stimulus meets this by changing inputs only on the falling clock edge and by holding every strobe level for a full clock. It sets `cle`, `ale` and the data byte one clock before the write strobe rises and keeps them there one clock after. The array powers up unknown, so the stimulus erases block 0 before it reads any stored page.

// File: rtl/nand_front.sv
module nand_front #(
  parameter int MAIN_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ARRAY_PAGES     = 2,
  parameter int RST_CYCLES      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        we_n,
  input  logic        re_n,
  input  logic        wp_n,
  input  logic [7:0]  dq_in,
  output logic [7:0]  dq_out,
  output logic        dq_oe,
  output logic        rb_n,
  output logic        cmd_err,
  output logic [2:0]  busy_op,
  output logic [11:0] col_addr,
  output logic [15:0] row_addr
);

  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int PB_BITS    = $clog2(PAGES_PER_BLOCK);
  localparam int AP_BITS    = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1;
  localparam int MEM_WORDS  = ARRAY_PAGES * PAGE_BYTES;
  localparam int MA_BITS    = $clog2(MEM_WORDS);

  localparam logic [11:0] PAGE_END  = 12'(PAGE_BYTES);
  localparam logic [11:0] PAGE_LAST = 12'(PAGE_BYTES - 1);
  localparam logic [11:0] RST_LAST  = 12'(RST_CYCLES - 1);
  localparam logic [AP_BITS-1:0] PG_LAST = AP_BITS'(ARRAY_PAGES - 1);

  localparam logic [2:0] ST_IDLE = 3'd0, ST_RADDR = 3'd1, ST_PADDR = 3'd2,
                         ST_EADDR = 3'd3, ST_ROUT = 3'd4, ST_RNDA = 3'd5;
  localparam logic [2:0] OP_NONE = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2,
                         OP_ERASE = 3'd3, OP_RESET = 3'd4;

  logic [2:0]  state;
  logic [2:0]  acnt;
  logic        col_only;
  logic        stat_mode;
  logic        fail;
  logic        we_q, re_q;
  logic [7:0]  dq_q;
  logic [11:0] sw_col;
  logic [AP_BITS-1:0] sw_pg;

  logic [7:0] mem  [MEM_WORDS];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] wmask;

  wire busy     = busy_op != OP_NONE;
  wire we_rise  = !ce_n && !we_q && we_n;
  wire re_fall  = !ce_n && re_q && !re_n;
  wire cmd_cyc  = we_rise && cle && !ale;
  wire addr_cyc = we_rise && ale && !cle && !busy;
  wire data_cyc = we_rise && !cle && !ale && !busy;
  wire col_in   = col_addr < PAGE_END;
  wire buf_wr   = data_cyc && state == ST_PADDR && col_in;
  wire row_hit  = row_addr < 16'(ARRAY_PAGES);
  wire blk_hit  = (16'(sw_pg) >> PB_BITS) == (row_addr >> PB_BITS);
  wire [7:0] status_byte = {wp_n, ~busy, 5'b00000, fail};

  wire [MA_BITS-1:0] acc_a = MA_BITS'(row_addr[AP_BITS-1:0]) * MA_BITS'(PAGE_BYTES)
                           + MA_BITS'(sw_col);
  wire [MA_BITS-1:0] er_a  = MA_BITS'(sw_pg) * MA_BITS'(PAGE_BYTES) + MA_BITS'(sw_col);

  assign dq_out = dq_q;
  assign dq_oe  = !ce_n && !re_n;
  assign rb_n   = !busy;

  logic              mem_we;
  logic [MA_BITS-1:0] mem_wa;
  logic [7:0]        mem_wd;

  always_comb begin
    mem_we = 1'b0;
    mem_wa = acc_a;
    mem_wd = 8'hFF;
    if (busy_op == OP_PROG) begin
      mem_we = row_hit;
      mem_wd = mem[acc_a] & (wmask[sw_col] ? pbuf[sw_col] : 8'hFF);
    end else if (busy_op == OP_ERASE) begin
      mem_we = blk_hit;
      mem_wa = er_a;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (busy_op == OP_READ)
      pbuf[sw_col] <= row_hit ? mem[acc_a] : 8'hFF;
    else if (buf_wr)
      pbuf[col_addr] <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wmask <= '0;
    else if (cmd_cyc && !busy && dq_in == 8'h80)
      wmask <= '0;
    else if (buf_wr)
      wmask[col_addr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      busy_op   <= OP_NONE;
      sw_col    <= '0;
      sw_pg     <= '0;
      col_addr  <= '0;
      row_addr  <= '0;
      acnt      <= '0;
      col_only  <= 1'b0;
      stat_mode <= 1'b0;
      fail      <= 1'b0;
      cmd_err   <= 1'b0;
      we_q      <= 1'b1;
      re_q      <= 1'b1;
      dq_q      <= 8'hFF;
    end else begin
      we_q <= we_n;
      re_q <= re_n;

      case (busy_op)
        OP_READ, OP_PROG: begin
          if (sw_col == PAGE_LAST) begin
            busy_op <= OP_NONE;
            sw_col  <= '0;
            state   <= (busy_op == OP_READ) ? ST_ROUT : ST_IDLE;
          end else begin
            sw_col <= sw_col + 12'd1;
          end
        end
        OP_ERASE: begin
          if (sw_col == PAGE_LAST) begin
            sw_col <= '0;
            if (sw_pg == PG_LAST) begin
              busy_op <= OP_NONE;
              sw_pg   <= '0;
            end else begin
              sw_pg <= sw_pg + 1'b1;
            end
          end else begin
            sw_col <= sw_col + 12'd1;
          end
        end
        OP_RESET: begin
          if (sw_col == RST_LAST) begin
            busy_op <= OP_NONE;
            sw_col  <= '0;
          end else begin
            sw_col <= sw_col + 12'd1;
          end
        end
        default: ;
      endcase

      if (re_fall) begin
        if (stat_mode)
          dq_q <= status_byte;
        else if (state == ST_ROUT && !busy) begin
          dq_q     <= col_in ? pbuf[col_addr] : 8'hFF;
          col_addr <= col_addr + 12'd1;
        end
      end

      if (addr_cyc && (state == ST_RADDR || state == ST_PADDR ||
                       state == ST_EADDR || state == ST_RNDA)) begin
        if (acnt != 3'd7) acnt <= acnt + 3'd1;
        if (state == ST_EADDR) begin
          if (acnt == 3'd0) row_addr[7:0]  <= dq_in;
          if (acnt == 3'd1) row_addr[15:8] <= dq_in;
        end else if (col_only) begin
          if (acnt == 3'd0) col_addr[7:0]  <= dq_in;
          if (acnt == 3'd1) col_addr[11:8] <= dq_in[3:0];
        end else begin
          case (acnt)
            3'd0: col_addr[7:0]  <= dq_in;
            3'd1: col_addr[11:8] <= dq_in[3:0];
            3'd2: row_addr[7:0]  <= dq_in;
            3'd3: row_addr[15:8] <= dq_in;
            default: ;
          endcase
        end
      end

      if (data_cyc && state == ST_PADDR)
        col_addr <= col_addr + 12'd1;

      if (cmd_cyc) begin
        if (dq_in == 8'hFF) begin
          busy_op   <= OP_RESET;
          sw_col    <= '0;
          sw_pg     <= '0;
          state     <= ST_IDLE;
          acnt      <= '0;
          col_only  <= 1'b0;
          stat_mode <= 1'b0;
          fail      <= 1'b0;
          cmd_err   <= 1'b0;
        end else if (dq_in == 8'h70) begin
          stat_mode <= 1'b1;
          cmd_err   <= 1'b0;
        end else if (!busy) begin
          stat_mode <= 1'b0;
          cmd_err   <= 1'b0;
          case (dq_in)
            8'h00, 8'h80, 8'h60: begin
              state    <= (dq_in == 8'h00) ? ST_RADDR :
                          (dq_in == 8'h80) ? ST_PADDR : ST_EADDR;
              acnt     <= '0;
              col_only <= 1'b0;
            end
            8'h30: begin
              if (state == ST_RADDR) begin
                busy_op <= OP_READ;
                sw_col  <= '0;
                state   <= ST_IDLE;
              end else begin
                state   <= ST_IDLE;
                cmd_err <= 1'b1;
              end
            end
            8'h85: begin
              if (state == ST_PADDR) begin
                acnt     <= '0;
                col_only <= 1'b1;
              end else begin
                state   <= ST_IDLE;
                cmd_err <= 1'b1;
              end
            end
            8'h10, 8'hD0: begin
              state <= ST_IDLE;
              if ((dq_in == 8'h10 && state == ST_PADDR) ||
                  (dq_in == 8'hD0 && state == ST_EADDR)) begin
                if (wp_n) begin
                  busy_op <= (dq_in == 8'h10) ? OP_PROG : OP_ERASE;
                  sw_col  <= '0;
                  sw_pg   <= '0;
                  fail    <= 1'b0;
                end else begin
                  fail <= 1'b1;
                end
              end else begin
                cmd_err <= 1'b1;
              end
            end
            8'h05: begin
              if (state == ST_ROUT) begin
                state    <= ST_RNDA;
                acnt     <= '0;
                col_only <= 1'b1;
              end else begin
                state   <= ST_IDLE;
                cmd_err <= 1'b1;
              end
            end
            8'hE0: begin
              if (state == ST_RNDA) begin
                state <= ST_ROUT;
              end else begin
                state   <= ST_IDLE;
                cmd_err <= 1'b1;
              end
            end
            default: begin
              state   <= ST_IDLE;
              cmd_err <= 1'b1;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nand_front_checker.sv
module nand_front_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        cle,
  input logic        wp_n,
  input logic        cmd_err,
  input logic [2:0]  busy_op,
  input logic [11:0] col_addr,
  input logic [15:0] row_addr
);

  assert_ce_high_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> ($stable(col_addr) && $stable(row_addr)));

  assert_start_needs_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_op != 3'd0 && $past(busy_op) == 3'd0) |-> $past(cle && !ce_n));

  assert_busy_holds_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_op) != 3'd0) |-> ($stable(row_addr) && $stable(col_addr)));

  assert_err_from_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(cle && !ce_n));

  assert_prog_needs_wp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_op == 3'd2 && $past(busy_op) != 3'd2) |-> $past(wp_n));

  assert_erase_needs_wp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_op == 3'd3 && $past(busy_op) != 3'd3) |-> $past(wp_n));

endmodule

bind nand_front nand_front_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .wp_n(wp_n),
  .cmd_err(cmd_err), .busy_op(busy_op), .col_addr(col_addr), .row_addr(row_addr)
);

// File: tb/nand_front_test.sv
module nand_front_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0]  dq_in = 8'h00;
  logic [7:0]  dq_out;
  logic        dq_oe, rb_n, cmd_err;
  logic [2:0]  busy_op;
  logic [11:0] col_addr;
  logic [15:0] row_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int         low_cnt = 0;

  always #2 clk = ~clk;

  nand_front uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rb_n(rb_n), .cmd_err(cmd_err), .busy_op(busy_op), .col_addr(col_addr),
    .row_addr(row_addr)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // scoreboard monitor: compares each read-strobe byte with the queued expectation
  always @(negedge clk) begin
    if (!re_n) begin
      low_cnt++;
      if (low_cnt == 1) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL scoreboard: actual 0x%0h expected none queued", dq_out);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (dq_out !== e || !dq_oe) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, dq_out, e);
          end
        end
      end
    end else begin
      low_cnt = 0;
    end
  end

  task automatic bus(input logic c, input logic a, input logic [7:0] d, input logic ce);
    @(negedge clk);
    ce_n <= ce; cle <= c; ale <= a; dq_in <= d; we_n <= 1'b0;
    @(negedge clk);
    we_n <= 1'b1;
    @(negedge clk);
    cle <= 1'b0; ale <= 1'b0; ce_n <= 1'b0;
  endtask

  task automatic put_cmd(input logic [7:0] c);  bus(1'b1, 1'b0, c, 1'b0); endtask
  task automatic put_addr(input logic [7:0] a); bus(1'b0, 1'b1, a, 1'b0); endtask
  task automatic put_data(input logic [7:0] d); bus(1'b0, 1'b0, d, 1'b0); endtask

  task automatic rd_expect(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); re_n <= 1'b0;
    @(negedge clk);
    @(negedge clk); re_n <= 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!rb_n) @(negedge clk);
  endtask

  task automatic full_addr(input logic [11:0] c, input logic [15:0] r);
    put_addr(c[7:0]); put_addr({4'h0, c[11:8]}); put_addr(r[7:0]); put_addr(r[15:8]);
  endtask

  task automatic load_page(input logic [11:0] c, input logic [15:0] r);
    put_cmd(8'h00); full_addr(c, r); put_cmd(8'h30); wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    finish_test();
  end

  initial begin
    int n;
    logic [11:0] snap;
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    ce_n  <= 1'b0;
    @(negedge clk);
    check_eq("R10 reset rb_n", rb_n, 1);
    check_eq("R10 reset busy_op", busy_op, 0);
    check_eq("R12 reset cmd_err", cmd_err, 0);
    check_eq("R1 reset dq_oe", dq_oe, 0);

    put_cmd(8'h70);
    rd_expect(8'hC0, "R9 idle status");

    put_cmd(8'hFF);
    check_eq("R10 reset op while ready", busy_op, 4);
    n = 0;
    while (!rb_n) begin n++; @(negedge clk); end
    check_eq("R10 busy length", n, 8);

    put_cmd(8'h60); put_addr(8'h00); put_addr(8'h00); put_cmd(8'hD0);
    check_eq("R6 erase op", busy_op, 3);
    wait_ready();
    put_cmd(8'h60); put_addr(8'h40); put_addr(8'h00); put_addr(8'h55);
    check_eq("R3 erase row", row_addr, 16'h0040);
    put_cmd(8'hD0); wait_ready();

    put_cmd(8'h80);
    put_addr(8'h34); put_addr(8'hF8); put_addr(8'h01); put_addr(8'h00); put_addr(8'h99);
    check_eq("R2 column", col_addr, 12'h834);
    check_eq("R2 row", row_addr, 16'h0001);
    put_data(8'hA1); put_data(8'hB2); put_data(8'hC3); put_data(8'hD4); put_data(8'hE5);
    put_cmd(8'h85); put_addr(8'h10); put_addr(8'h00);
    check_eq("R8 moved column", col_addr, 12'h010);
    put_data(8'h5A); put_data(8'h69);
    put_cmd(8'h85); put_addr(8'h3F); put_addr(8'h08);
    put_data(8'h77); put_data(8'h88);
    put_cmd(8'h10);
    check_eq("R5 program busy", rb_n, 0);
    wait_ready();

    load_page(12'h010, 16'h0001);
    rd_expect(8'h5A, "R4 byte 16");
    rd_expect(8'h69, "R4 byte 17");
    rd_expect(8'hFF, "R4 byte 18 erased");
    put_cmd(8'h05); put_addr(8'h34); put_addr(8'h08); put_cmd(8'hE0);
    rd_expect(8'hA1, "R7 spare 2100");
    rd_expect(8'hB2, "R7 spare 2101");
    rd_expect(8'hC3, "R7 spare 2102");
    rd_expect(8'hD4, "R7 spare 2103");
    rd_expect(8'hE5, "R7 spare 2104");
    put_cmd(8'h05); put_addr(8'h3F); put_addr(8'h08); put_cmd(8'hE0);
    rd_expect(8'h77, "R14 last column");
    rd_expect(8'hFF, "R14 past page end");

    put_cmd(8'h80); full_addr(12'h010, 16'h0001); put_data(8'h0F); put_cmd(8'h10);
    wait_ready();
    load_page(12'h010, 16'h0001);
    rd_expect(8'h0A, "R5 and-program");
    rd_expect(8'h69, "R5 unloaded column kept");
    load_page(12'h010, 16'h0000);
    rd_expect(8'hFF, "R5 other row untouched");

    put_cmd(8'h60); put_addr(8'h00); put_addr(8'h00); put_cmd(8'hD0);
    check_eq("R6 erase running", busy_op, 3);
    put_cmd(8'h70);
    rd_expect(8'h80, "R9 busy status");
    snap = col_addr;
    put_cmd(8'h00); put_addr(8'h22);
    check_eq("R11 column held", col_addr, snap);
    check_eq("R11 op held", busy_op, 3);
    wait_ready();
    rd_expect(8'hC0, "R9 status after erase");
    load_page(12'h834, 16'h0001);
    rd_expect(8'hFF, "R6 erased spare");

    put_cmd(8'h00); full_addr(12'h000, 16'h0001); put_cmd(8'h30);
    check_eq("R4 read op", busy_op, 1);
    put_cmd(8'hFF);
    check_eq("R10 reset aborts read", busy_op, 4);
    n = 0;
    while (!rb_n) begin n++; @(negedge clk); end
    check_eq("R10 abort busy length", n, 8);

    put_cmd(8'h42);
    check_eq("R12 undefined command", cmd_err, 1);
    put_cmd(8'h00);
    check_eq("R12 error cleared", cmd_err, 0);
    put_cmd(8'h10);
    check_eq("R12 misplaced confirm", cmd_err, 1);
    check_eq("R12 no operation", busy_op, 0);

    wp_n <= 1'b0;
    put_cmd(8'h80); full_addr(12'h000, 16'h0000); put_data(8'h00); put_cmd(8'h10);
    check_eq("R13 program refused", rb_n, 1);
    put_cmd(8'h60); put_addr(8'h00); put_addr(8'h00); put_cmd(8'hD0);
    check_eq("R13 erase refused", busy_op, 0);
    put_cmd(8'h70);
    rd_expect(8'h41, "R13 status fail");
    wp_n <= 1'b1;
    load_page(12'h000, 16'h0000);
    rd_expect(8'hFF, "R13 array unchanged");

    bus(1'b1, 1'b0, 8'hFF, 1'b1);
    check_eq("R1 command with ce_n high", busy_op, 0);
    put_cmd(8'h00);
    snap = col_addr;
    bus(1'b0, 1'b1, 8'h77, 1'b1);
    check_eq("R1 address with ce_n high", col_addr, snap);

    repeat (4) @(negedge clk);
    finish_test();
  end

endmodule